// File: doc/BRIEF.md
# Vector Timestamp Synchronization Unit

This block holds one vector logical clock per thread of a small multiprocessor. Each clock advances only at lock acquire and lock release events, so an epoch runs from one synchronization point to the next. A release bumps the releasing thread's own component, stores the result in a per-lock stamp register and presents it on a log port, so the stamp can be recorded for later replay. An acquire merges the lock's stored stamp into the thread's clock and then bumps the thread's own component.

A comparator port takes two thread ids and reports, one cycle later, whether their clocks are equal, ordered one way or the other, or concurrent. Accesses made in concurrent epochs that conflict are data race candidates. Instruction decoding, memory and lock arbitration are left to the surrounding system. Each clock component is 16 bits wide by default. An increment that would wrap is refused and raises a sticky error.

Top module: `vts_sync_unit`

## Requirements
- R1: After reset every thread clock and every lock stamp is all zeros, `log_valid_o`, `cmp_valid_o` and `err_o` are low, and a compare of any two threads reports code 0 (equal).
- R2: A release event (`ev_kind_i`=1) adds one to the thread's own component and stores the result in the lock's stamp register. In the next cycle it raises `log_valid_o` with the thread id, the lock id and that stamp. Component i occupies bits [i*CW +: CW]. Example: thread 0 at (1,0,..) releasing gives a log of (2,0,..).
- R3: An acquire event (`ev_kind_i`=0) sets the thread clock to the element-wise maximum of the clock and the lock's stamp, then adds one to the own component. Example: thread 1 at all zeros acquiring a lock stamped (2,0,..) becomes (2,1,..).
- R4: Lock stamps are kept per lock id. Acquiring a lock that has never been released only adds one to the own component.
- R5: A compare request (`cmp_valid_i`) is answered with `cmp_valid_o` high exactly one cycle later, and never otherwise.
- R6: `cmp_ord_o` encodes: 0 equal, 1 clock A happened before clock B, 2 B happened before A, 3 concurrent. X happened before Y when every component of X is <= the matching component of Y and the two differ.
- R7: A compare issued in the same cycle as a sync event is judged on the clocks as they were before that event.
- R8: An event whose own-component increment would exceed the all-ones value is dropped: no clock, no lock stamp and no log change. `err_o` rises in the next cycle and stays high until reset.
- R9: An acquire never raises `log_valid_o`.
- R10: An event on one thread leaves the clocks of all other threads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Sync event present this cycle |
| ev_kind_i | input | 1 | 0 acquire, 1 release |
| ev_tid_i | input | TW | Thread issuing the event |
| ev_lid_i | input | LW | Lock involved |
| log_valid_o | output | 1 | Release stamp on the log port |
| log_tid_o | output | TW | Releasing thread |
| log_lid_o | output | LW | Released lock |
| log_ts_o | output | NT*CW | Release stamp, component i at [i*CW +: CW] |
| err_o | output | 1 | Sticky clock-overflow error |
| cmp_valid_i | input | 1 | Compare request |
| cmp_a_tid_i | input | TW | Thread whose clock is A |
| cmp_b_tid_i | input | TW | Thread whose clock is B |
| cmp_valid_o | output | 1 | Compare response valid |
| cmp_ord_o | output | 2 | Ordering code of A versus B |

## Verification
A sync event and a compare request can arrive in the same cycle, and the compare may name the very thread the event is updating. The bench drives a release on thread 3 together with a compare of threads 3 and 4. It expects the answer equal, because both clocks were still zero before the event. The following compare must then report thread 4 as happening before thread 3. A release and an overflow refusal also meet in one cycle of the log port. After 65535 releases on thread 7, one more release must produce no log entry and must leave the lock's stamp unchanged, as a later acquire of that lock shows.

// File: rtl/vts_pkg.sv
package vts_pkg;
  typedef enum logic {SYNC_ACQ = 1'b0, SYNC_REL = 1'b1} sync_kind_e;
  typedef enum logic [1:0] {
    ORD_EQUAL   = 2'd0,
    ORD_A_FIRST = 2'd1,
    ORD_B_FIRST = 2'd2,
    ORD_CONC    = 2'd3
  } order_e;
endpackage

// File: rtl/vts_clock_file.sv
module vts_clock_file #(
  parameter int NT = 8,
  parameter int CW = 16,
  parameter int TW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [TW-1:0]    wtid_i,
  input  logic [NT*CW-1:0] wdata_i,
  input  logic [TW-1:0]    ev_tid_i,
  input  logic [TW-1:0]    a_tid_i,
  input  logic [TW-1:0]    b_tid_i,
  output logic [NT*CW-1:0] ev_ts_o,
  output logic [NT*CW-1:0] a_ts_o,
  output logic [NT*CW-1:0] b_ts_o
);
  logic [NT*CW-1:0] clk_q [NT];

  for (genvar t = 0; t < NT; t++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          clk_q[t] <= '0;
      else if (we_i && wtid_i == TW'(t))    clk_q[t] <= wdata_i;
    end
  end

  assign ev_ts_o = clk_q[ev_tid_i];
  assign a_ts_o  = clk_q[a_tid_i];
  assign b_ts_o  = clk_q[b_tid_i];
endmodule

// File: rtl/vts_lock_file.sv
module vts_lock_file #(
  parameter int NT = 8,
  parameter int NL = 16,
  parameter int CW = 16,
  parameter int LW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LW-1:0]    wlid_i,
  input  logic [NT*CW-1:0] wdata_i,
  input  logic [LW-1:0]    rlid_i,
  output logic [NT*CW-1:0] rdata_o
);
  logic [NT*CW-1:0] stamp_q [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          stamp_q[l] <= '0;
      else if (we_i && wlid_i == LW'(l))    stamp_q[l] <= wdata_i;
    end
  end

  assign rdata_o = stamp_q[rlid_i];
endmodule

// File: rtl/vts_step.sv
module vts_step #(
  parameter int NT = 8,
  parameter int CW = 16,
  parameter int TW = 3
) (
  input  logic [NT*CW-1:0] cur_i,
  input  logic [NT*CW-1:0] lck_i,
  input  logic             acq_i,
  input  logic [TW-1:0]    tid_i,
  output logic [NT*CW-1:0] nxt_o,
  output logic             ovf_o
);
  logic [CW-1:0] base [NT];

  for (genvar t = 0; t < NT; t++) begin : g_cmp
    logic [CW-1:0] c, l;
    assign c = cur_i[t*CW +: CW];
    assign l = lck_i[t*CW +: CW];
    // merge on acquire, pass-through on release
    assign base[t] = (acq_i && l > c) ? l : c;
    assign nxt_o[t*CW +: CW] = (tid_i == TW'(t)) ? base[t] + CW'(1) : base[t];
  end

  assign ovf_o = &base[tid_i];
endmodule

// File: rtl/vts_cmp.sv
module vts_cmp
  import vts_pkg::*;
#(
  parameter int NT = 8,
  parameter int CW = 16
) (
  input  logic [NT*CW-1:0] a_i,
  input  logic [NT*CW-1:0] b_i,
  output order_e           ord_o
);
  logic [NT-1:0] a_le_b, b_le_a;

  for (genvar t = 0; t < NT; t++) begin : g_el
    assign a_le_b[t] = a_i[t*CW +: CW] <= b_i[t*CW +: CW];
    assign b_le_a[t] = b_i[t*CW +: CW] <= a_i[t*CW +: CW];
  end

  always_comb begin
    unique case ({&a_le_b, &b_le_a})
      2'b11:   ord_o = ORD_EQUAL;
      2'b10:   ord_o = ORD_A_FIRST;
      2'b01:   ord_o = ORD_B_FIRST;
      default: ord_o = ORD_CONC;
    endcase
  end
endmodule

// File: rtl/vts_sync_unit.sv
module vts_sync_unit
  import vts_pkg::*;
#(
  parameter int NT = 8,
  parameter int NL = 16,
  parameter int CW = 16,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1,
  localparam int VW = NT * CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_valid_i,
  input  logic          ev_kind_i,
  input  logic [TW-1:0] ev_tid_i,
  input  logic [LW-1:0] ev_lid_i,
  output logic          log_valid_o,
  output logic [TW-1:0] log_tid_o,
  output logic [LW-1:0] log_lid_o,
  output logic [VW-1:0] log_ts_o,
  output logic          err_o,
  input  logic          cmp_valid_i,
  input  logic [TW-1:0] cmp_a_tid_i,
  input  logic [TW-1:0] cmp_b_tid_i,
  output logic          cmp_valid_o,
  output logic [1:0]    cmp_ord_o
);
  logic [VW-1:0] ev_ts, a_ts, b_ts, lck_ts, nxt_ts;
  logic          is_acq, is_rel, step_ovf, fire;
  order_e        ord;

  assign is_acq = sync_kind_e'(ev_kind_i) == SYNC_ACQ;
  assign is_rel = !is_acq;
  assign fire   = ev_valid_i && !step_ovf;

  vts_clock_file #(.NT(NT), .CW(CW), .TW(TW)) u_clocks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (fire),
    .wtid_i   (ev_tid_i),
    .wdata_i  (nxt_ts),
    .ev_tid_i (ev_tid_i),
    .a_tid_i  (cmp_a_tid_i),
    .b_tid_i  (cmp_b_tid_i),
    .ev_ts_o  (ev_ts),
    .a_ts_o   (a_ts),
    .b_ts_o   (b_ts)
  );

  vts_lock_file #(.NT(NT), .NL(NL), .CW(CW), .LW(LW)) u_locks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fire && is_rel),
    .wlid_i  (ev_lid_i),
    .wdata_i (nxt_ts),
    .rlid_i  (ev_lid_i),
    .rdata_o (lck_ts)
  );

  vts_step #(.NT(NT), .CW(CW), .TW(TW)) u_step (
    .cur_i (ev_ts),
    .lck_i (lck_ts),
    .acq_i (is_acq),
    .tid_i (ev_tid_i),
    .nxt_o (nxt_ts),
    .ovf_o (step_ovf)
  );

  vts_cmp #(.NT(NT), .CW(CW)) u_cmp (
    .a_i   (a_ts),
    .b_i   (b_ts),
    .ord_o (ord)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log_valid_o <= 1'b0;
      log_tid_o   <= '0;
      log_lid_o   <= '0;
      log_ts_o    <= '0;
      err_o       <= 1'b0;
      cmp_valid_o <= 1'b0;
      cmp_ord_o   <= '0;
    end else begin
      log_valid_o <= fire && is_rel;
      if (fire && is_rel) begin
        log_tid_o <= ev_tid_i;
        log_lid_o <= ev_lid_i;
        log_ts_o  <= nxt_ts;
      end
      err_o       <= err_o || (ev_valid_i && step_ovf);
      cmp_valid_o <= cmp_valid_i;
      if (cmp_valid_i) cmp_ord_o <= ord;
    end
  end
endmodule

// File: rtl/vts_sync_chk.sv
module vts_sync_chk #(
  parameter int NT = 8,
  parameter int NL = 16,
  parameter int CW = 16,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1,
  localparam int VW = NT * CW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ev_valid_i,
  input logic          ev_kind_i,
  input logic [TW-1:0] ev_tid_i,
  input logic [LW-1:0] ev_lid_i,
  input logic          log_valid_o,
  input logic [TW-1:0] log_tid_o,
  input logic [LW-1:0] log_lid_o,
  input logic [VW-1:0] log_ts_o,
  input logic          err_o,
  input logic          cmp_valid_i,
  input logic [TW-1:0] cmp_a_tid_i,
  input logic [TW-1:0] cmp_b_tid_i,
  input logic          cmp_valid_o,
  input logic [1:0]    cmp_ord_o
);
  logic [CW-1:0] log_own;
  assign log_own = log_ts_o[log_tid_o*CW +: CW];

  AST_ACQ_NO_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !ev_kind_i) |=> !log_valid_o); // R9
  AST_IDLE_NO_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> !log_valid_o); // R2
  AST_LOG_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_kind_i) |=> (!log_valid_o ||
      (log_tid_o == $past(ev_tid_i) && log_lid_o == $past(ev_lid_i)))); // R2
  AST_LOG_OWN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_valid_o |-> log_own != '0); // R2
  AST_CMP_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> cmp_valid_o); // R5
  AST_CMP_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> !cmp_valid_o); // R5
  AST_CMP_SELF_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && cmp_a_tid_i == cmp_b_tid_i) |=> cmp_ord_o == 2'd0); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_ERR_NO_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !log_valid_o); // R8
endmodule

bind vts_sync_unit vts_sync_chk #(.NT(NT), .NL(NL), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_valid_i  (ev_valid_i),
  .ev_kind_i   (ev_kind_i),
  .ev_tid_i    (ev_tid_i),
  .ev_lid_i    (ev_lid_i),
  .log_valid_o (log_valid_o),
  .log_tid_o   (log_tid_o),
  .log_lid_o   (log_lid_o),
  .log_ts_o    (log_ts_o),
  .err_o       (err_o),
  .cmp_valid_i (cmp_valid_i),
  .cmp_a_tid_i (cmp_a_tid_i),
  .cmp_b_tid_i (cmp_b_tid_i),
  .cmp_valid_o (cmp_valid_o),
  .cmp_ord_o   (cmp_ord_o)
);

// File: tb/tb_vts_sync_unit.sv
`timescale 1ns/1ps
module tb_vts_sync_unit;
  localparam int NT = 8, NL = 16, CW = 16;
  localparam int TW = 3, LW = 4, VW = NT * CW;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          ev_valid_i = 1'b0, ev_kind_i = 1'b0;
  logic [TW-1:0] ev_tid_i = '0;
  logic [LW-1:0] ev_lid_i = '0;
  logic          log_valid_o, err_o, cmp_valid_o;
  logic [TW-1:0] log_tid_o;
  logic [LW-1:0] log_lid_o;
  logic [VW-1:0] log_ts_o;
  logic          cmp_valid_i = 1'b0;
  logic [TW-1:0] cmp_a_tid_i = '0, cmp_b_tid_i = '0;
  logic [1:0]    cmp_ord_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  vts_sync_unit #(.NT(NT), .NL(NL), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ev_valid_i(ev_valid_i), .ev_kind_i(ev_kind_i),
    .ev_tid_i(ev_tid_i), .ev_lid_i(ev_lid_i),
    .log_valid_o(log_valid_o), .log_tid_o(log_tid_o),
    .log_lid_o(log_lid_o), .log_ts_o(log_ts_o), .err_o(err_o),
    .cmp_valid_i(cmp_valid_i), .cmp_a_tid_i(cmp_a_tid_i),
    .cmp_b_tid_i(cmp_b_tid_i), .cmp_valid_o(cmp_valid_o),
    .cmp_ord_o(cmp_ord_o)
  );

  function automatic logic [VW-1:0] v8(int c0, int c1, int c2, int c3,
                                       int c4, int c5, int c6, int c7);
    logic [VW-1:0] r;
    r = {CW'(c7), CW'(c6), CW'(c5), CW'(c4), CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
    return r;
  endfunction

  task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one event, returns at the negedge after the capturing edge
  task automatic sync_ev(logic kind, int tid, int lid);
    ev_valid_i = 1'b1; ev_kind_i = kind;
    ev_tid_i = TW'(tid); ev_lid_i = LW'(lid);
    @(negedge clk);
    ev_valid_i = 1'b0;
  endtask

  task automatic compare(string req, int a, int b, int exp_ord);
    cmp_valid_i = 1'b1; cmp_a_tid_i = TW'(a); cmp_b_tid_i = TW'(b);
    @(negedge clk);
    cmp_valid_i = 1'b0;
    chk({req, " cmp valid"}, VW'(cmp_valid_o), VW'(1));
    chk({req, " cmp order"}, VW'(cmp_ord_o), VW'(exp_ord));
  endtask

  task automatic chk_log(string req, int tid, int lid, logic [VW-1:0] ts);
    chk({req, " log valid"}, VW'(log_valid_o), VW'(1));
    chk({req, " log tid"}, VW'(log_tid_o), VW'(tid));
    chk({req, " log lid"}, VW'(log_lid_o), VW'(lid));
    chk({req, " log ts"}, log_ts_o, ts);
  endtask

  task automatic t_reset();
    chk("R1 log idle", VW'(log_valid_o), '0);
    chk("R1 cmp idle", VW'(cmp_valid_o), '0);
    chk("R1 err low", VW'(err_o), '0);
    compare("R1", 0, 1, 0);
  endtask

  task automatic t_release_acquire();
    sync_ev(1'b0, 0, 0);
    chk("R9 acquire no log", VW'(log_valid_o), '0);
    sync_ev(1'b1, 0, 0);
    chk_log("R2", 0, 0, v8(2,0,0,0,0,0,0,0));
    sync_ev(1'b0, 1, 0);
    chk("R9 acquire no log t1", VW'(log_valid_o), '0);
    sync_ev(1'b1, 1, 5);
    chk_log("R3 merge", 1, 5, v8(2,2,0,0,0,0,0,0));
    compare("R6 a first", 0, 1, 1);
    compare("R6 b first", 1, 0, 2);
  endtask

  task automatic t_fresh_lock();
    sync_ev(1'b0, 2, 9);
    sync_ev(1'b1, 2, 9);
    chk_log("R4 fresh lock", 2, 9, v8(0,0,2,0,0,0,0,0));
    compare("R6 concurrent", 0, 2, 3);
  endtask

  task automatic t_same_cycle();
    ev_valid_i = 1'b1; ev_kind_i = 1'b1; ev_tid_i = 3'd3; ev_lid_i = 4'd10;
    cmp_valid_i = 1'b1; cmp_a_tid_i = 3'd3; cmp_b_tid_i = 3'd4;
    @(negedge clk);
    ev_valid_i = 1'b0; cmp_valid_i = 1'b0;
    chk("R7 cmp valid", VW'(cmp_valid_o), VW'(1));
    chk("R7 old clocks equal", VW'(cmp_ord_o), VW'(0));
    chk_log("R7 release", 3, 10, v8(0,0,0,1,0,0,0,0));
    compare("R7 after event", 3, 4, 2);
  endtask

  task automatic t_isolation();
    compare("R10 t4 t5 untouched", 4, 5, 0);
    compare("R10 t6 t7 untouched", 6, 7, 0);
    compare("R5 back to back", 0, 0, 0);
  endtask

  task automatic t_overflow();
    ev_valid_i = 1'b1; ev_kind_i = 1'b1; ev_tid_i = 3'd7; ev_lid_i = 4'd15;
    repeat (65535) @(negedge clk);
    ev_valid_i = 1'b0;
    chk_log("R8 at max", 7, 15, v8(0,0,0,0,0,0,0,65535));
    chk("R8 err before", VW'(err_o), '0);
    sync_ev(1'b1, 7, 15);
    chk("R8 dropped no log", VW'(log_valid_o), '0);
    chk("R8 err set", VW'(err_o), VW'(1));
    sync_ev(1'b0, 6, 15);
    sync_ev(1'b1, 6, 14);
    chk_log("R8 lock stamp kept", 6, 14, v8(0,0,0,0,0,0,2,65535));
    chk("R8 err sticky", VW'(err_o), VW'(1));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_release_acquire();
    t_fresh_lock();
    t_same_cycle();
    t_isolation();
    t_overflow();
    finish_run();
  end
endmodule